// File: doc/BRIEF.md
# Per-Cell Voltage Fault Qualifier

This block watches a stack of up to sixteen battery cell voltages, each delivered as a millivolt code on a wide bus. All cells are sampled together on a shared strobe. Separate overvoltage and undervoltage paths compare every enabled cell against a trip threshold and a recovery threshold. The two thresholds form a hysteresis band.

Each polarity has one shared delay timer. The timer advances on an internal 1 ms tick while at least one cell is past the trip threshold. It holds its count while the cells sit in the hysteresis band. It clears only when every enabled cell has crossed back past the recovery threshold. A qualified flag is raised when the timer has counted the configured number of ticks.

A test-mode input swaps both delays for a short fixed delay, which speeds up production checks. Cells reading below an absolute floor are treated as absent for undervoltage purposes. Slots beyond the configured cell count are ignored.

Top module: `cvq_fault_qual`

## Requirements
- R1: An overvoltage violation exists when any enabled cell code is strictly greater than OV_TH_MV. A code equal to OV_TH_MV is not a violation.
- R2: An undervoltage violation exists when any enabled cell code is at or above UV_FLOOR_MV and strictly below UV_TH_MV. A code equal to UV_TH_MV is not a violation.
- R3: A cell code below UV_FLOOR_MV never causes an undervoltage violation. Such a cell counts as recovered for undervoltage.
- R4: `ov_flag` rises once the overvoltage violation has been seen on OV_DLY_TICKS ticks. A tick occurs every CLK_PER_TICK clocks. The flag stays high while the violation persists.
- R5: `uv_flag` rises once the undervoltage violation has been seen on UV_DLY_TICKS ticks.
- R6: The overvoltage timer and flag clear when every enabled cell is below OV_TH_MV - OV_HYS_MV. The undervoltage timer and flag clear when every enabled cell is above UV_TH_MV + UV_HYS_MV or below the floor. The flag is low within two clocks of the strobe that captured the recovered voltages. A later violation needs the full delay again.
- R7: A sample that shows neither a violation nor full recovery (hysteresis band) leaves the flag unchanged. It also freezes the timer count: the count neither restarts nor clears.
- R8: While `test_mode` is 1, both delays are TEST_DLY_TICKS ticks instead of their normal values.
- R9: Cell slots with index NUM_CELLS or above have no effect on either flag.
- R10: Reset drives both flags low.
- R11: Cell codes are captured only on clocks where `sample_vld` is 1. Changes on `cell_mv` without a strobe have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_vld | input | 1 | Strobe: capture all cell codes this clock |
| cell_mv | input | MAX_CELLS*CODE_W | Cell codes in mV, cell i at bits [i*CODE_W +: CODE_W] |
| test_mode | input | 1 | 1 selects the short test delay for both timers |
| ov_flag | output | 1 | Qualified overvoltage fault |
| uv_flag | output | 1 | Qualified undervoltage fault |

## Verification
The bench builds the block with four enabled cells on the full sixteen-slot bus and a tick every four clocks. Its delays are 8 ticks for overvoltage, 5 ticks for undervoltage and 2 ticks in test mode. With these settings each qualification window lasts a few tens of cycles, so every enabled cell can be swept through trip, band and recovery at the exact threshold codes. The unused slots are driven with faulting codes to show that they are ignored. The short delays also separate a frozen timer from a restarted one by a full tick period, which makes the band-hold behaviour measurable at the flag.

// File: rtl/cvq_pkg.sv
package cvq_pkg;
  typedef struct packed {
    logic viol;
    logic rec;
  } cvq_cond_t;

  function automatic int cvq_max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/cvq_tick_gen.sv
module cvq_tick_gen #(
  parameter int DIV = 200000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int TW = $clog2(DIV);
      localparam logic [TW-1:0] LAST = TW'(DIV - 1);
      logic [TW-1:0] cnt_q, cnt_d;

      always_comb begin
        if (cnt_q == LAST) cnt_d = '0;
        else               cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/cvq_cell_cmp.sv
module cvq_cell_cmp
  import cvq_pkg::*;
#(
  parameter int CODE_W    = 13,
  parameter int MAX_CELLS = 16,
  parameter int NUM_CELLS = 16,
  parameter int OV_TH     = 4300,
  parameter int OV_REC    = 4200,
  parameter int UV_TH     = 2500,
  parameter int UV_REC    = 2600,
  parameter int FLOOR     = 500
) (
  input  logic [MAX_CELLS*CODE_W-1:0] cell_mv,
  output cvq_cond_t                   ov_c,
  output cvq_cond_t                   uv_c
);
  localparam logic [CODE_W-1:0] OV_TH_C  = CODE_W'(OV_TH);
  localparam logic [CODE_W-1:0] OV_REC_C = CODE_W'(OV_REC);
  localparam logic [CODE_W-1:0] UV_TH_C  = CODE_W'(UV_TH);
  localparam logic [CODE_W-1:0] UV_REC_C = CODE_W'(UV_REC);
  localparam logic [CODE_W-1:0] FLOOR_C  = CODE_W'(FLOOR);

  logic [MAX_CELLS-1:0] ov_hi, ov_ok, uv_lo, uv_ok;

  generate
    for (genvar i = 0; i < MAX_CELLS; i++) begin : g_cell
      if (i < NUM_CELLS) begin : g_on
        logic [CODE_W-1:0] v;
        logic              below_floor;
        assign v           = cell_mv[i*CODE_W +: CODE_W];
        assign below_floor = (v < FLOOR_C);
        assign ov_hi[i]    = (v > OV_TH_C);
        assign ov_ok[i]    = (v < OV_REC_C);
        assign uv_lo[i]    = !below_floor && (v < UV_TH_C);
        assign uv_ok[i]    = below_floor || (v > UV_REC_C);
      end else begin : g_off
        assign ov_hi[i] = 1'b0;
        assign ov_ok[i] = 1'b1;
        assign uv_lo[i] = 1'b0;
        assign uv_ok[i] = 1'b1;
      end
    end
  endgenerate

  assign ov_c.viol = |ov_hi;
  assign ov_c.rec  = &ov_ok;
  assign uv_c.viol = |uv_lo;
  assign uv_c.rec  = &uv_ok;
endmodule

// File: rtl/cvq_delay_timer.sv
module cvq_delay_timer #(
  parameter int CNT_W    = 12,
  parameter int NORM_DLY = 1000,
  parameter int TEST_DLY = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic test_mode,
  input  logic viol,
  input  logic rec,
  output logic flag
);
  localparam logic [CNT_W-1:0] NORM_C = CNT_W'(NORM_DLY);
  localparam logic [CNT_W-1:0] TEST_C = CNT_W'(TEST_DLY);

  logic [CNT_W-1:0] cnt_q, cnt_d, dly;
  logic [CNT_W:0]   cnt_inc;
  logic             flag_q, flag_d, step_en;

  assign dly     = test_mode ? TEST_C : NORM_C;
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign step_en = viol && tick && !flag_q;

  always_comb begin
    cnt_d  = cnt_q;
    flag_d = flag_q;
    if (rec) begin
      cnt_d  = '0;
      flag_d = 1'b0;
    end else if (step_en) begin
      cnt_d = cnt_inc[CNT_W-1:0];
      if (cnt_inc >= {1'b0, dly}) flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/cvq_fault_qual.sv
module cvq_fault_qual
  import cvq_pkg::*;
#(
  parameter int CODE_W       = 13,
  parameter int MAX_CELLS    = 16,
  parameter int NUM_CELLS    = 16,
  parameter int CLK_PER_TICK = 200000,
  parameter int OV_TH_MV     = 4325,
  parameter int OV_HYS_MV    = 100,
  parameter int UV_TH_MV     = 2250,
  parameter int UV_HYS_MV    = 100,
  parameter int UV_FLOOR_MV  = 500,
  parameter int OV_DLY_TICKS = 1000,
  parameter int UV_DLY_TICKS = 1000,
  parameter int TEST_DLY_TICKS = 50
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sample_vld,
  input  logic [MAX_CELLS*CODE_W-1:0] cell_mv,
  input  logic                        test_mode,
  output logic                        ov_flag,
  output logic                        uv_flag
);
  localparam int MAX_DLY = cvq_max3(OV_DLY_TICKS, UV_DLY_TICKS, TEST_DLY_TICKS);
  localparam int CNT_W   = $clog2(MAX_DLY + 1);

  cvq_cond_t ov_c, uv_c;
  logic      tick;
  logic      ov_viol_q, ov_rec_q, uv_viol_q, uv_rec_q;
  logic      ov_viol_d, ov_rec_d, uv_viol_d, uv_rec_d;

  cvq_tick_gen #(.DIV(CLK_PER_TICK)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  cvq_cell_cmp #(
    .CODE_W(CODE_W), .MAX_CELLS(MAX_CELLS), .NUM_CELLS(NUM_CELLS),
    .OV_TH(OV_TH_MV), .OV_REC(OV_TH_MV - OV_HYS_MV),
    .UV_TH(UV_TH_MV), .UV_REC(UV_TH_MV + UV_HYS_MV),
    .FLOOR(UV_FLOOR_MV)
  ) u_cmp (
    .cell_mv(cell_mv), .ov_c(ov_c), .uv_c(uv_c)
  );

  always_comb begin
    ov_viol_d = ov_viol_q;
    ov_rec_d  = ov_rec_q;
    uv_viol_d = uv_viol_q;
    uv_rec_d  = uv_rec_q;
    if (sample_vld) begin
      ov_viol_d = ov_c.viol;
      ov_rec_d  = ov_c.rec;
      uv_viol_d = uv_c.viol;
      uv_rec_d  = uv_c.rec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_viol_q <= 1'b0;
      ov_rec_q  <= 1'b0;
      uv_viol_q <= 1'b0;
      uv_rec_q  <= 1'b0;
    end else begin
      ov_viol_q <= ov_viol_d;
      ov_rec_q  <= ov_rec_d;
      uv_viol_q <= uv_viol_d;
      uv_rec_q  <= uv_rec_d;
    end
  end

  cvq_delay_timer #(
    .CNT_W(CNT_W), .NORM_DLY(OV_DLY_TICKS), .TEST_DLY(TEST_DLY_TICKS)
  ) u_ov_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .test_mode(test_mode),
    .viol(ov_viol_q), .rec(ov_rec_q), .flag(ov_flag)
  );

  cvq_delay_timer #(
    .CNT_W(CNT_W), .NORM_DLY(UV_DLY_TICKS), .TEST_DLY(TEST_DLY_TICKS)
  ) u_uv_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .test_mode(test_mode),
    .viol(uv_viol_q), .rec(uv_rec_q), .flag(uv_flag)
  );
endmodule

// File: rtl/cvq_checker.sv
module cvq_checker (
  input logic clk,
  input logic rst_n,
  input logic sample_vld,
  input logic tick,
  input logic ov_viol,
  input logic ov_rec,
  input logic uv_viol,
  input logic uv_rec,
  input logic ov_flag,
  input logic uv_flag
);
  AST_OV_REC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ov_rec |=> !ov_flag); // R6
  AST_UV_REC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    uv_rec |=> !uv_flag); // R6
  AST_OV_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ov_flag) |-> ($past(ov_viol) && $past(tick))); // R4
  AST_UV_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uv_flag) |-> ($past(uv_viol) && $past(tick))); // R5
  AST_OV_BAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ov_viol && !ov_rec) |=> $stable(ov_flag)); // R7
  AST_UV_BAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!uv_viol && !uv_rec) |=> $stable(uv_flag)); // R7
  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld |=> ($stable(ov_viol) && $stable(uv_viol) &&
                     $stable(ov_rec) && $stable(uv_rec))); // R11
endmodule

bind cvq_fault_qual cvq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .tick(tick),
  .ov_viol(ov_viol_q), .ov_rec(ov_rec_q),
  .uv_viol(uv_viol_q), .uv_rec(uv_rec_q),
  .ov_flag(ov_flag), .uv_flag(uv_flag)
);

// File: tb/tb_cvq_fault_qual.sv
`timescale 1ns/1ps
module tb_cvq_fault_qual;
  localparam int CW = 13, MC = 16, NC = 4, P = 4;
  localparam int OVT = 4200, OVH = 100, UVT = 2500, UVH = 200, FL = 500;
  localparam int OVD = 8, UVD = 5, TD = 2;
  localparam int NOM = 3700;

  logic clk = 1'b0, rst_n = 1'b0, sample_vld = 1'b0, test_mode = 1'b0;
  logic [MC*CW-1:0] cell_mv;
  logic [CW-1:0] cv [MC];
  logic ov_flag, uv_flag;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  always_comb for (int i = 0; i < MC; i++) cell_mv[i*CW +: CW] = cv[i];

  cvq_fault_qual #(
    .CODE_W(CW), .MAX_CELLS(MC), .NUM_CELLS(NC), .CLK_PER_TICK(P),
    .OV_TH_MV(OVT), .OV_HYS_MV(OVH), .UV_TH_MV(UVT), .UV_HYS_MV(UVH),
    .UV_FLOOR_MV(FL), .OV_DLY_TICKS(OVD), .UV_DLY_TICKS(UVD),
    .TEST_DLY_TICKS(TD)
  ) dut (
    .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .cell_mv(cell_mv),
    .test_mode(test_mode), .ov_flag(ov_flag), .uv_flag(uv_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic nominal();
    for (int i = 0; i < MC; i++) cv[i] = (i < NC) ? CW'(NOM) : '0;
  endtask

  task automatic strobe();
    @(negedge clk) sample_vld = 1'b1;
    @(negedge clk) sample_vld = 1'b0;
  endtask

  task automatic wait_rise(input bit which_uv, output int n);
    n = 0;
    while (((which_uv ? uv_flag : ov_flag) == 1'b0) && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #(5ns * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    nominal();
    idle(3);
    chk("R10 ov after reset", ov_flag, 0);
    chk("R10 uv after reset", uv_flag, 0);
    rst_n = 1'b1;
    strobe();
    idle(60);
    chk("R1 nominal ov", ov_flag, 0);
    chk("R2 nominal uv", uv_flag, 0);

    // R1 equality boundary
    cv[0] = CW'(OVT);
    strobe(); idle(60);
    chk("R1 code equal to OV threshold", ov_flag, 0);

    for (int c = 0; c < NC; c++) begin
      nominal(); cv[c] = CW'(OVT + 1);
      strobe(); wait_rise(1'b0, n);
      chk_rng($sformatf("R4 ov delay cell %0d", c), n, (OVD-1)*P, OVD*P+2);
      chk($sformatf("R1 no uv on ov cell %0d", c), uv_flag, 0);
      cv[c] = CW'(OVT - OVH);
      strobe(); idle(40);
      chk($sformatf("R7 ov band holds cell %0d", c), ov_flag, 1);
      cv[c] = CW'(OVT - OVH - 1);
      strobe(); idle(2);
      chk($sformatf("R6 ov recovery cell %0d", c), ov_flag, 0);
    end

    nominal(); cv[1] = CW'(UVT);
    strobe(); idle(60);
    chk("R2 code equal to UV threshold", uv_flag, 0);

    for (int c = 0; c < NC; c++) begin
      nominal(); cv[c] = CW'(UVT - 1);
      strobe(); wait_rise(1'b1, n);
      chk_rng($sformatf("R5 uv delay cell %0d", c), n, (UVD-1)*P, UVD*P+2);
      chk($sformatf("R2 no ov on uv cell %0d", c), ov_flag, 0);
      cv[c] = CW'(UVT + UVH);
      strobe(); idle(40);
      chk($sformatf("R7 uv band holds cell %0d", c), uv_flag, 1);
      cv[c] = CW'(UVT + UVH + 1);
      strobe(); idle(2);
      chk($sformatf("R6 uv recovery cell %0d", c), uv_flag, 0);
    end

    // floor
    nominal(); cv[2] = CW'(FL - 1);
    strobe(); idle(60);
    chk("R3 below floor ignored", uv_flag, 0);
    cv[2] = CW'(FL);
    strobe(); wait_rise(1'b1, n);
    chk_rng("R3 at floor counts as uv", n, (UVD-1)*P, UVD*P+2);
    cv[2] = CW'(400);
    strobe(); idle(2);
    chk("R3 dropping below floor recovers", uv_flag, 0);

    // ignored slots
    nominal();
    for (int i = NC; i < MC; i++) cv[i] = (i % 2) ? CW'(5000) : CW'(800);
    strobe(); idle(60);
    chk("R9 upper slots ov", ov_flag, 0);
    chk("R9 upper slots uv", uv_flag, 0);

    // no strobe
    nominal(); cv[0] = CW'(4500); cv[3] = CW'(1200);
    idle(60);
    chk("R11 no strobe ov", ov_flag, 0);
    chk("R11 no strobe uv", uv_flag, 0);
    nominal(); strobe(); idle(4);

    // band freezes the timer
    cv[1] = CW'(OVT + 50);
    strobe(); idle(10);
    cv[1] = CW'(OVT - 50);
    strobe(); idle(80);
    chk("R7 band freezes ov timer", ov_flag, 0);
    cv[1] = CW'(OVT + 50);
    strobe(); wait_rise(1'b0, n);
    chk_rng("R7 timer resumes not restarts", n, 1, (OVD-1)*P-1);
    nominal(); strobe(); idle(2);
    chk("R6 ov cleared after resume", ov_flag, 0);

    // test mode
    test_mode = 1'b1;
    cv[0] = CW'(4600);
    strobe(); wait_rise(1'b0, n);
    chk_rng("R8 test ov delay", n, (TD-1)*P, TD*P+2);
    nominal(); cv[3] = CW'(1500);
    strobe(); wait_rise(1'b1, n);
    chk_rng("R8 test uv delay", n, (TD-1)*P, TD*P+2);
    idle(2);
    chk("R6 ov cleared in test mode", ov_flag, 0);
    nominal(); strobe(); idle(2);
    chk("R6 uv cleared in test mode", uv_flag, 0);
    test_mode = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule